// File: doc/BRIEF.md
# ADC Result Threshold Monitor and Accumulator

This block sits behind a converter and inspects every signed 16-bit conversion result that arrives with a valid strobe. It takes the magnitude of the result, with the sign discarded, and compares it with a programmable threshold. Depending on the comparator mode, the block raises its interrupt flag on every result whose magnitude is above the threshold, or it counts results above (or below) the threshold and raises the flag only after a programmable number of them.

Alongside the comparator, a 32-bit accumulator adds or subtracts each sign-extended result. Its running value is presented on an output port so software can read it directly. A small write-only register port sets the threshold, the counter limit and the two mode fields. The same port also carries strobes that clear the interrupt flag, the event counter and the accumulator.

Register map on `wr_addr`:
- 0: mode. Bits [1:0] select the comparator mode; bits [3:2] select the accumulator mode.
- 1: threshold, unsigned, in bits [15:0].
- 2: counter limit, in bits [15:0].
- 3: control strobes. Bit 0 clears the flag, bit 1 clears the counter, bit 2 clears the accumulator.

Top module: `adc_result_monitor`

## Requirements
- R1: The comparison uses the magnitude of the two's-complement result, so the sign has no effect. A result of -32768 (16'h8000) has magnitude 32767: it is above a threshold of 32766 and not above a threshold of 32767.
- R2: In comparator mode 2'b01, a valid result whose magnitude is strictly greater than the threshold sets the flag. A result equal to the threshold does not set it.
- R3: In comparator mode 2'b10, each valid result with magnitude strictly above the threshold increments `thr_count`.
- R4: In comparator mode 2'b11, each valid result with magnitude strictly below the threshold increments `thr_count`. In either counting mode, a magnitude equal to the threshold leaves the count unchanged.
- R5: When an increment makes the count greater than or equal to the limit, the flag is set and `thr_count` returns to 0. A limit of 0 or 1 therefore fires on every qualifying result.
- R6: The flag (`irq`) is sticky until a write to address 3 with bit 0 set. If a set event occurs in the same cycle as that clear, the flag ends up set.
- R7: In accumulator mode 2'b01, each valid result is sign-extended and added to `acc_value`; in mode 2'b10 it is subtracted. Modes 2'b00 and 2'b11 hold the value. All arithmetic wraps modulo 2^32.
- R8: A write to address 3 with bit 2 set clears `acc_value` to 0, and it takes precedence over an accumulation in the same cycle.
- R9: A write to address 3 with bit 1 set clears `thr_count` to 0, and it takes precedence over an increment in the same cycle. A qualifying event discarded this way does not set the flag.
- R10: In comparator mode 2'b00, results neither set the flag nor change the count.
- R11: After a synchronous active-low reset, `irq`, `thr_count` and `acc_value` read 0, and the threshold, limit and both modes are 0.
- R12: Outputs reflect a result one clock after its valid cycle. A register write takes effect from the following cycle, so a result arriving in the same cycle as a write is processed with the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | Conversion result strobe |
| res_data | input | 16 | Signed conversion result |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| irq | output | 1 | Sticky interrupt flag |
| thr_count | output | 16 | Threshold event counter |
| acc_value | output | 32 | Running accumulator |

## Verification
The assertions assume `res_valid`, `wr_en` and the address and data buses are known (0 or 1) at every clock edge after reset. They also assume the limit is not moved while a count is in progress, except where the firing rule of R5 covers a lowered limit. The stimulus holds these assumptions by driving every input from the bench on the falling edge and returning it to idle after each cycle. The random stimulus mixes in -32768, values equal to the threshold and its neighbours, so the equality and saturation cases arise often.

// File: rtl/adcmon_pkg.sv
// Package: shared encodings for the ADC result monitor.
// Assumes: register addresses are two bits wide.
package adcmon_pkg;

    // Comparator behaviour selected by the mode register, bits [1:0]
    typedef enum logic [1:0] {
        CMP_OFF       = 2'b00,
        CMP_EACH      = 2'b01,
        CMP_CNT_ABOVE = 2'b10,
        CMP_CNT_BELOW = 2'b11
    } cmp_mode_e;

    // Accumulator behaviour selected by the mode register, bits [3:2]
    typedef enum logic [1:0] {
        ACC_HOLD  = 2'b00,
        ACC_ADD   = 2'b01,
        ACC_SUB   = 2'b10,
        ACC_HOLD3 = 2'b11
    } acc_mode_e;

    typedef struct packed {
        acc_mode_e acc;
        cmp_mode_e cmp;
    } mode_t;

    localparam logic [1:0] ADDR_MODE  = 2'd0;
    localparam logic [1:0] ADDR_THR   = 2'd1;
    localparam logic [1:0] ADDR_LIMIT = 2'd2;
    localparam logic [1:0] ADDR_CTRL  = 2'd3;

    localparam int CTRL_CLR_IRQ = 0;
    localparam int CTRL_CLR_CNT = 1;
    localparam int CTRL_CLR_ACC = 2;

endpackage

// File: rtl/adcmon_regs.sv
// Module: adcmon_regs
// Holds the mode, threshold and limit registers, and decodes the clear strobes.
// Assumes: the bus width equals DATA_W, CNT_W <= DATA_W, and the strobes are
// combinational from the write so that the consumers can order them same-cycle.
module adcmon_regs
    import adcmon_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output mode_t             mode,
    output logic [DATA_W-1:0] threshold,
    output logic [CNT_W-1:0]  limit,
    output logic              clr_irq,
    output logic              clr_cnt,
    output logic              clr_acc
);

    localparam int MODE_W = $bits(mode_t);

    logic is_ctrl;

    // Control writes produce single-cycle clear pulses
    always_comb begin
        is_ctrl = wr_en && (wr_addr == ADDR_CTRL);
        clr_irq = is_ctrl && wr_data[CTRL_CLR_IRQ];
        clr_cnt = is_ctrl && wr_data[CTRL_CLR_CNT];
        clr_acc = is_ctrl && wr_data[CTRL_CLR_ACC];
    end

    // Configuration register file with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= '{acc: ACC_HOLD, cmp: CMP_OFF};
            threshold <= '0;
            limit     <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_MODE:  mode      <= mode_t'(wr_data[MODE_W-1:0]);
                ADDR_THR:   threshold <= wr_data;
                ADDR_LIMIT: limit     <= wr_data[CNT_W-1:0];
                default:    ;
            endcase
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(threshold) && $stable(limit) && $stable(mode))); // R12

endmodule

// File: rtl/adcmon_magcmp.sv
// Module: adcmon_magcmp
// Forms the saturated magnitude of a signed result and compares it with the threshold.
// Assumes: the result is two's complement; the most negative code maps to the largest positive value.
module adcmon_magcmp #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] res_data,
    input  logic [DATA_W-1:0] threshold,
    output logic              above,
    output logic              below
);

    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

    logic [DATA_W-1:0] mag;

    // Magnitude with saturation of the single unrepresentable case
    always_comb begin
        if (res_data == MOST_NEG)
            mag = MOST_POS;
        else if (res_data[DATA_W-1])
            mag = (~res_data) + 1'b1;
        else
            mag = res_data;
    end

    // Strict comparisons; equality yields neither flag
    always_comb begin
        above = mag > threshold;
        below = mag < threshold;
    end

    AST_MAG_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !mag[DATA_W-1]); // R1
    AST_ABOVE_BELOW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(above && below)); // R4

endmodule

// File: rtl/adcmon_thrcount.sv
// Module: adcmon_thrcount
// Counts qualifying results and drives the sticky interrupt flag.
// Assumes: above/below are strict comparisons of the current result; the clears are single-cycle strobes.
module adcmon_thrcount
    import adcmon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  cmp_mode_e        cmp_mode,
    input  logic             above,
    input  logic             below,
    input  logic [CNT_W-1:0] limit,
    input  logic             clr_irq,
    input  logic             clr_cnt,
    output logic [CNT_W-1:0] count,
    output logic             irq
);

    localparam int EXT_W = CNT_W + 1;

    logic             qualify;
    logic             hit;
    logic             each_set;
    logic [EXT_W-1:0] next_cnt;

    // Event qualification and limit detection
    always_comb begin
        qualify  = res_valid && !clr_cnt &&
                   (((cmp_mode == CMP_CNT_ABOVE) && above) ||
                    ((cmp_mode == CMP_CNT_BELOW) && below));
        next_cnt = {1'b0, count} + 1'b1;
        hit      = qualify && (next_cnt >= {1'b0, limit});
        each_set = res_valid && (cmp_mode == CMP_EACH) && above;
    end

    // Event counter: clear wins, restart to zero on reaching the limit
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr_cnt || hit)
            count <= '0;
        else if (qualify)
            count <= next_cnt[CNT_W-1:0];
    end

    // Sticky flag: a set event outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (each_set || hit)
            irq <= 1'b1;
        else if (clr_irq)
            irq <= 1'b0;
    end

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_irq) |=> irq); // R6
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && !clr_cnt) |=> $stable(count)); // R3
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cnt |=> (count == '0)); // R9
    AST_HIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (count == '0 && irq)); // R5
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_mode == CMP_OFF && !clr_cnt) |=> $stable(count)); // R10

endmodule

// File: rtl/adcmon_accum.sv
// Module: adcmon_accum
// Adds or subtracts each sign-extended result into a wrapping accumulator.
// Assumes: ACC_W > DATA_W; the clear strobe lasts one cycle and outranks accumulation.
module adcmon_accum
    import adcmon_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  acc_mode_e         acc_mode,
    input  logic              clr_acc,
    output logic [ACC_W-1:0]  acc
);

    localparam int EXT_W = ACC_W - DATA_W;

    logic [ACC_W-1:0] sample;

    // Sign extension of the incoming result
    always_comb sample = {{EXT_W{res_data[DATA_W-1]}}, res_data};

    // Accumulator update: clear first, then add or subtract, else hold
    always_ff @(posedge clk) begin
        if (!rst_n || clr_acc)
            acc <= '0;
        else if (res_valid && acc_mode == ACC_ADD)
            acc <= acc + sample;
        else if (res_valid && acc_mode == ACC_SUB)
            acc <= acc - sample;
    end

    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_acc |=> (acc == '0)); // R8
    AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && !clr_acc) |=> $stable(acc)); // R7

endmodule

// File: rtl/adc_result_monitor.sv
// Module: adc_result_monitor
// Top level: register port, magnitude comparator, event counter and accumulator.
// Assumes: one result per valid cycle; the register port is write-only and single-cycle.
module adc_result_monitor
    import adcmon_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq,
    output logic [CNT_W-1:0]  thr_count,
    output logic [ACC_W-1:0]  acc_value
);

    mode_t             mode;
    logic [DATA_W-1:0] threshold;
    logic [CNT_W-1:0]  limit;
    logic              clr_irq;
    logic              clr_cnt;
    logic              clr_acc;
    logic              above;
    logic              below;

    adcmon_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .mode      (mode),
        .threshold (threshold),
        .limit     (limit),
        .clr_irq   (clr_irq),
        .clr_cnt   (clr_cnt),
        .clr_acc   (clr_acc)
    );

    adcmon_magcmp #(.DATA_W(DATA_W)) u_magcmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_data  (res_data),
        .threshold (threshold),
        .above     (above),
        .below     (below)
    );

    adcmon_thrcount #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .cmp_mode  (mode.cmp),
        .above     (above),
        .below     (below),
        .limit     (limit),
        .clr_irq   (clr_irq),
        .clr_cnt   (clr_cnt),
        .count     (thr_count),
        .irq       (irq)
    );

    adcmon_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_data  (res_data),
        .acc_mode  (mode.acc),
        .clr_acc   (clr_acc),
        .acc       (acc_value)
    );

endmodule

// File: tb/tb_adc_result_monitor.sv
module tb_adc_result_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        irq;
    logic [15:0] thr_count;
    logic [31:0] acc_value;

    int checks = 0;
    int fails  = 0;

    // Bench model state
    logic [1:0]  m_cmp, m_accm;
    logic [15:0] m_thr, m_lim, m_cnt;
    logic        m_irq;
    logic [31:0] m_acc;

    adc_result_monitor dut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq(irq), .thr_count(thr_count), .acc_value(acc_value)
    );

    always #4 clk = ~clk;

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    function automatic logic [15:0] f_mag(input logic [15:0] x);
        if (x == 16'h8000) return 16'h7FFF;
        if (x[15]) return (~x) + 16'd1;
        return x;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Model update for the edge that has just occurred, from the driven inputs
    task automatic model_step();
        logic ci, cc, ca, qual, setf;
        logic [15:0] mg;
        logic [16:0] n;
        if (!rst_n) begin
            m_cmp = 0; m_accm = 0; m_thr = 0; m_lim = 0;
            m_cnt = 0; m_irq = 0; m_acc = 0;
            return;
        end
        ci = wr_en && wr_addr == 2'd3 && wr_data[0];
        cc = wr_en && wr_addr == 2'd3 && wr_data[1];
        ca = wr_en && wr_addr == 2'd3 && wr_data[2];
        mg = f_mag(res_data);
        qual = 0; setf = 0;
        if (res_valid) begin
            if (m_cmp == 2'b01) setf = mg > m_thr;
            if (m_cmp == 2'b10) qual = mg > m_thr;
            if (m_cmp == 2'b11) qual = mg < m_thr;
        end
        if (cc) m_cnt = 0;
        else if (qual) begin
            n = {1'b0, m_cnt} + 17'd1;
            if (n >= {1'b0, m_lim}) begin m_cnt = 0; setf = 1; end
            else m_cnt = n[15:0];
        end
        if (setf) m_irq = 1; else if (ci) m_irq = 0;
        if (ca) m_acc = 0;
        else if (res_valid && m_accm == 2'b01) m_acc = m_acc + {{16{res_data[15]}}, res_data};
        else if (res_valid && m_accm == 2'b10) m_acc = m_acc - {{16{res_data[15]}}, res_data};
        if (wr_en) case (wr_addr)
            2'd0: begin m_cmp = wr_data[1:0]; m_accm = wr_data[3:2]; end
            2'd1: m_thr = wr_data;
            2'd2: m_lim = wr_data;
            default: ;
        endcase
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(tag, {31'd0, irq}, {31'd0, m_irq});
        chk(tag, {16'd0, thr_count}, {16'd0, m_cnt});
        chk(tag, acc_value, m_acc);
    endtask

    // Drive one cycle of stimulus, then return inputs to idle
    task automatic drive(input logic v, input logic [15:0] d, input logic we,
                         input logic [1:0] a, input logic [15:0] wd, input string tag);
        res_valid = v; res_data = d; wr_en = we; wr_addr = a; wr_data = wd;
        tick(tag);
        res_valid = 0; wr_en = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] wd, input string tag);
        drive(0, 16'd0, 1, a, wd, tag);
    endtask

    task automatic res(input logic [15:0] d, input string tag);
        drive(1, d, 0, 2'd0, 16'd0, tag);
    endtask

    initial begin
        void'($urandom(32'hACC0_1234));
        @(negedge clk);
        rst_n = 0;
        tick("R11"); tick("R11"); tick("R11");
        rst_n = 1;
        chk("R11 irq", {31'd0, irq}, 32'd0);
        chk("R11 count", {16'd0, thr_count}, 32'd0);
        chk("R11 acc", acc_value, 32'd0);

        // R1: magnitude and saturation
        wr(2'd0, 16'h0001, "R1");
        wr(2'd1, 16'd32766, "R1");
        res(16'h8000, "R1");
        chk("R1 sat above 32766", {31'd0, irq}, 32'd1);
        wr(2'd3, 16'h0001, "R6");
        wr(2'd1, 16'd32767, "R1");
        res(16'h8000, "R1");
        chk("R1 sat not above 32767", {31'd0, irq}, 32'd0);
        wr(2'd1, 16'd4, "R1");
        res(16'hFFFB, "R1");
        chk("R1 sign ignored", {31'd0, irq}, 32'd1);
        wr(2'd3, 16'h0001, "R6");

        // R2: strict comparison
        wr(2'd1, 16'd100, "R2");
        res(16'd100, "R2");
        chk("R2 equal no irq", {31'd0, irq}, 32'd0);
        res(16'd101, "R2");
        chk("R2 above irq", {31'd0, irq}, 32'd1);

        // R6: sticky, clear, set wins
        tick("R6"); tick("R6");
        chk("R6 sticky", {31'd0, irq}, 32'd1);
        wr(2'd3, 16'h0001, "R6");
        chk("R6 cleared", {31'd0, irq}, 32'd0);
        drive(1, 16'd200, 1, 2'd3, 16'h0001, "R6");
        chk("R6 set beats clear", {31'd0, irq}, 32'd1);
        wr(2'd3, 16'h0001, "R6");

        // R10: comparator off
        wr(2'd0, 16'h0000, "R10");
        res(16'h7FFF, "R10");
        chk("R10 no irq", {31'd0, irq}, 32'd0);
        chk("R10 no count", {16'd0, thr_count}, 32'd0);

        // R3 and R5: count above, limit 3
        wr(2'd0, 16'h0002, "R3");
        wr(2'd2, 16'd3, "R5");
        wr(2'd1, 16'd10, "R3");
        res(16'd11, "R3");
        res(16'hFFEC, "R3");
        chk("R3 count two", {16'd0, thr_count}, 32'd2);
        res(16'd10, "R4");
        chk("R4 equal not counted", {16'd0, thr_count}, 32'd2);
        chk("R5 no irq before limit", {31'd0, irq}, 32'd0);
        res(16'd30, "R5");
        chk("R5 restart", {16'd0, thr_count}, 32'd0);
        chk("R5 irq at limit", {31'd0, irq}, 32'd1);
        wr(2'd3, 16'h0001, "R6");

        // R4: count below
        wr(2'd0, 16'h0003, "R4");
        res(16'd10, "R4");
        chk("R4 equal ignored", {16'd0, thr_count}, 32'd0);
        res(16'hFFF7, "R4");
        chk("R4 below counted", {16'd0, thr_count}, 32'd1);
        res(16'd11, "R4");
        chk("R4 above not counted", {16'd0, thr_count}, 32'd1);

        // R9: clear beats increment
        drive(1, 16'd3, 1, 2'd3, 16'h0002, "R9");
        chk("R9 clear wins", {16'd0, thr_count}, 32'd0);
        chk("R9 no irq", {31'd0, irq}, 32'd0);

        // R5: limit zero fires each time
        wr(2'd2, 16'd0, "R5");
        res(16'd1, "R5");
        chk("R5 limit0 irq", {31'd0, irq}, 32'd1);
        chk("R5 limit0 count", {16'd0, thr_count}, 32'd0);
        wr(2'd3, 16'h0001, "R6");

        // R7: accumulate add, subtract with wrap, hold
        wr(2'd0, 16'h0004, "R7");
        res(16'd5, "R7");
        res(16'hFFFD, "R7");
        chk("R7 add signed", acc_value, 32'd2);
        wr(2'd0, 16'h0008, "R7");
        wr(2'd3, 16'h0004, "R8");
        res(16'd1, "R7");
        chk("R7 subtract wrap", acc_value, 32'hFFFF_FFFF);
        wr(2'd0, 16'h000C, "R7");
        res(16'd100, "R7");
        chk("R7 hold mode", acc_value, 32'hFFFF_FFFF);

        // R8: clear beats accumulate
        wr(2'd0, 16'h0004, "R8");
        drive(1, 16'd50, 1, 2'd3, 16'h0004, "R8");
        chk("R8 clear wins", acc_value, 32'd0);

        // R12: same-cycle write uses old mode
        drive(1, 16'd7, 1, 2'd0, 16'h0008, "R12");
        chk("R12 old mode add", acc_value, 32'd7);
        res(16'd7, "R12");
        chk("R12 new mode sub", acc_value, 32'd0);

        // Random phase, all outputs checked every cycle against the model
        for (int i = 0; i < 4000; i++) begin
            logic v, we;
            logic [1:0] a;
            logic [15:0] d, wd;
            int pick;
            v = ($urandom % 10) < 6;
            we = ($urandom % 10) < 2;
            a = 2'($urandom % 4);
            pick = $urandom % 8;
            case (pick)
                0: d = 16'h8000;
                1: d = m_thr;
                2: d = (~m_thr) + 16'd1;
                3: d = m_thr + 16'd1;
                default: d = 16'($urandom);
            endcase
            case (a)
                2'd0: wd = 16'($urandom % 16);
                2'd1: wd = ($urandom % 2) ? 16'($urandom % 64) : 16'($urandom);
                2'd2: wd = 16'($urandom % 5);
                default: wd = 16'($urandom % 8);
            endcase
            drive(v, d, we, a, wd, "R12 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule